// File: doc/BRIEF.md
# Four-Phase Configuration Register Slave

This block is a small register bank that sits on an internal configuration bus. The bus master drives a block select, a read strobe, a word address and a 32-bit write data bus. The slave answers on its own 32-bit read data bus and raises an acknowledge. The acknowledge stays high until the master removes the select, which forms a four-phase handshake. Because of this handshake the master may run from a clock that is unrelated to the slave clock. Inside the slave, the select and the read strobe pass through a synchroniser before they are used.

While the block is not selected, its read data and acknowledge are held at zero. This lets several slaves share one return path through a plain OR of their outputs. Behind the bus the bank holds four registers:

- a 32-bit control word that drives an output port;
- an interrupt enable mask;
- a sticky event status field that software clears by writing ones;
- a read-only view of a hardware status input.

The interrupt output is high while any enabled status bit is set.

Top module: `cfgAccessSlave`

## Requirements
- R1: While reset is held and just after it is released, ack, rdata, irq and ctrlOut are all zero.
- R2: Whenever sel is low, ack and rdata are zero in the same cycle, whatever the state of the other inputs.
- R3: When sel rises between two clock edges, ack rises after the third rising clock edge that follows. Ack then stays high for as long as sel stays high, and drops together with sel.
- R4: For a read (rd high together with sel), rdata carries the addressed register as it was at the acknowledging edge. Rdata does not change while ack stays high.
- R5: A write commits exactly once per sel assertion, however long sel is held. An event bit that sets during a long write to the status word therefore survives that write.
- R6: The address map, by word address on wordAddr (byte address bits 12 to 2), is as follows. Word 0 is the control word: 32 bits, read/write, and it drives ctrlOut. Word 1 is the interrupt enable: read/write in its low STAT_W bits, and its upper bits read as zero. Word 2 is the event status. Word 3 returns hwStatus, and writes to it are ignored.
- R7: A read from any other word address is acknowledged and returns zero. A write to such an address changes no register.
- R8: A status bit becomes set on any clock edge where the matching eventIn bit is high. It stays set until a write places a 1 in that bit position of word 2. Writing 0 leaves the bit unchanged. An event and a clear in the same cycle leave the bit set.
- R9: irq is high exactly when some status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slave clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Block select from the master, possibly asynchronous |
| rd | input | 1 | High for a read, low for a write; held with sel |
| wordAddr | input | 11 | Word address (byte address bits 12 to 2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; zero when not acknowledging |
| ack | output | 1 | Acknowledge; zero whenever sel is low |
| irq | output | 1 | Interrupt: OR of enabled status bits |
| eventIn | input | 8 | Event pulses that set status bits |
| hwStatus | input | 32 | Live hardware status, readable at word 3 |
| ctrlOut | output | 32 | Contents of the control word |

## Verification
The hardest case to reach from the ports is a write that is held for a long time and must not commit twice. A second commit leaves no mark on the control word, because it would write the same value again. The bench therefore holds a write of ones to the status word for many cycles and, in parallel, pulses an event after the commit has happened. The event bit then stays set only if the write committed once. The set-wins priority is reached in a similar way: eventIn is held high across a clearing write, and the bench then reads the bit back.

// File: rtl/cfgSlavePkg.sv
package cfgSlavePkg;

  // Word offsets of the mapped registers
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_ENABLE = 1;
  localparam int unsigned REG_STATUS = 2;
  localparam int unsigned REG_HWSTAT = 3;

  // Strobes issued by the handshake control to the register datapath
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } accStrobe_t;

endpackage

// File: rtl/cfgSyncChain.sv
module cfgSyncChain #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar g = 0; g < STAGES; g++) begin : stg
    logic [WIDTH-1:0] q;
    if (g == 0) begin : first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= din;
      end
    end else begin : later
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= stg[g-1].q;
      end
    end
  end

  assign dout = stg[STAGES-1].q;

endmodule

// File: rtl/cfgHandshakeCtrl.sv
module cfgHandshakeCtrl
  import cfgSlavePkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sel,
  input  logic       rd,
  output accStrobe_t strobe,
  output logic       ackOn
);

  logic [1:0] syncOut;
  logic       selSync;
  logic       rdSync;
  logic       selPrev;
  logic       ackReg;
  logic       startAcc;

  cfgSyncChain #(.STAGES(SYNC_STAGES), .WIDTH(2)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({rd, sel}),
    .dout (syncOut)
  );

  assign selSync = syncOut[0];
  assign rdSync  = syncOut[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selPrev <= 1'b0;
    else       selPrev <= selSync;
  end

  // One access per rising edge of the synchronised select
  assign startAcc = selSync & ~selPrev;

  always_comb begin
    strobe.wrEn = startAcc & ~rdSync;
    strobe.rdEn = startAcc &  rdSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ackReg <= 1'b0;
    else if (!selSync) ackReg <= 1'b0;
    else if (startAcc) ackReg <= 1'b1;
  end

  // Gate with the raw select so the bus output drops at once when deselected
  assign ackOn = ackReg & sel;

endmodule

// File: rtl/cfgRegBank.sv
module cfgRegBank
  import cfgSlavePkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 11,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        strobe,
  input  logic              ackOn,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STAT_W-1:0] eventIn,
  input  logic [DATA_W-1:0] hwStatus,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctrlOut,
  output logic              irq
);

  logic [DATA_W-1:0] ctrlReg;
  logic [STAT_W-1:0] enableReg;
  logic [STAT_W-1:0] statusReg;
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] readVal;
  logic [STAT_W-1:0] clearMask;
  logic              hitCtrl, hitEnable, hitStatus, hitHw;

  assign hitCtrl   = (wordAddr == ADDR_W'(REG_CTRL));
  assign hitEnable = (wordAddr == ADDR_W'(REG_ENABLE));
  assign hitStatus = (wordAddr == ADDR_W'(REG_STATUS));
  assign hitHw     = (wordAddr == ADDR_W'(REG_HWSTAT));

  always_comb begin
    readVal = '0;
    if (hitCtrl)   readVal = ctrlReg;
    if (hitEnable) readVal = DATA_W'(enableReg);
    if (hitStatus) readVal = DATA_W'(statusReg);
    if (hitHw)     readVal = hwStatus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      enableReg <= '0;
    end else if (strobe.wrEn) begin
      if (hitCtrl)   ctrlReg   <= wdata;
      if (hitEnable) enableReg <= wdata[STAT_W-1:0];
    end
  end

  assign clearMask = (strobe.wrEn && hitStatus) ? wdata[STAT_W-1:0] : '0;

  // New events take priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= (statusReg & ~clearMask) | eventIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           holdReg <= '0;
    else if (strobe.rdEn || strobe.wrEn) holdReg <= strobe.rdEn ? readVal : '0;
  end

  assign rdata   = ackOn ? holdReg : '0;
  assign ctrlOut = ctrlReg;
  assign irq     = |(statusReg & enableReg);

endmodule

// File: rtl/cfgAccessSlave.sv
module cfgAccessSlave
  import cfgSlavePkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 11,
  parameter int STAT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              rd,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ack,
  output logic              irq,
  input  logic [STAT_W-1:0] eventIn,
  input  logic [DATA_W-1:0] hwStatus,
  output logic [DATA_W-1:0] ctrlOut
);

  accStrobe_t strobe;
  logic       ackOn;

  cfgHandshakeCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .sel    (sel),
    .rd     (rd),
    .strobe (strobe),
    .ackOn  (ackOn)
  );

  cfgRegBank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_W(STAT_W)) uBank (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ackOn    (ackOn),
    .wordAddr (wordAddr),
    .wdata    (wdata),
    .eventIn  (eventIn),
    .hwStatus (hwStatus),
    .rdata    (rdata),
    .ctrlOut  (ctrlOut),
    .irq      (irq)
  );

  assign ack = ackOn;

endmodule

// File: rtl/cfgAccessSlaveChk.sv
module cfgAccessSlaveChk
  import cfgSlavePkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              sel,
  input logic              ack,
  input logic [DATA_W-1:0] rdata,
  input accStrobe_t        strobe
);

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sel |-> (ack == 1'b0 && rdata == '0));

  assert_ack_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ack) && sel) |-> ack);

  assert_ack_follows_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.wrEn || strobe.rdEn) && sel) |=> (ack || !sel));

  assert_rdata_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ack) && ack) |-> $stable(rdata));

  assert_single_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> !strobe.wrEn);

endmodule

bind cfgAccessSlave cfgAccessSlaveChk #(.DATA_W(DATA_W)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .sel    (sel),
  .ack    (ack),
  .rdata  (rdata),
  .strobe (strobe)
);

// File: tb/tb_cfgAccessSlave.sv
module tb_cfgAccessSlave;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0;
  logic        rd = 1'b0;
  logic [10:0] wordAddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack;
  logic        irq;
  logic [7:0]  eventIn = '0;
  logic [31:0] hwStatus = 32'h1357_9BDF;
  logic [31:0] ctrlOut;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;

  cfgAccessSlave dut (
    .clk(clk), .rstN(rstN), .sel(sel), .rd(rd), .wordAddr(wordAddr),
    .wdata(wdata), .rdata(rdata), .ack(ack), .irq(irq),
    .eventIn(eventIn), .hwStatus(hwStatus), .ctrlOut(ctrlOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced on every rising edge
  bit mS1, mS2, mPrev, mR1, mR2, mAck;
  logic [31:0] mCtrl, mHold;
  logic [7:0]  mEn, mStat;

  always @(posedge clk) begin
    bit start;
    logic [31:0] rv;
    logic [7:0] clr;
    if (!rstN) begin
      {mS1, mS2, mPrev, mR1, mR2, mAck} = '0;
      mCtrl = '0; mHold = '0; mEn = '0; mStat = '0;
    end else begin
      start = mS2 && !mPrev;
      case (wordAddr)
        11'd0:   rv = mCtrl;
        11'd1:   rv = {24'h0, mEn};
        11'd2:   rv = {24'h0, mStat};
        11'd3:   rv = hwStatus;
        default: rv = '0;
      endcase
      clr = (start && !mR2 && wordAddr == 11'd2) ? wdata[7:0] : 8'h0;
      if (start && !mR2) begin
        if (wordAddr == 11'd0) mCtrl = wdata;
        if (wordAddr == 11'd1) mEn = wdata[7:0];
      end
      mStat = (mStat & ~clr) | eventIn;
      if (start) mHold = mR2 ? rv : 32'h0;
      if (!mS2) mAck = 1'b0;
      else if (start) mAck = 1'b1;
      mPrev = mS2; mS2 = mS1; mS1 = sel;
      mR2 = mR1; mR1 = rd;
    end
  end

  // Per-cycle comparison, away from both clock edges
  always @(negedge clk) begin
    #2;
    if (running) begin
      chk("R3 ack", {31'h0, ack}, {31'h0, mAck && sel});
      chk("R4 rdata", rdata, (mAck && sel) ? mHold : 32'h0);
      chk("R9 irq", {31'h0, irq}, {31'h0, |(mStat & mEn)});
      chk("R6 ctrlOut", ctrlOut, mCtrl);
    end
  end

  task automatic access(input bit isRead, input logic [10:0] a, input logic [31:0] d,
                        input int holdCyc, output logic [31:0] got, output int lat);
    @(negedge clk);
    rd = isRead; wordAddr = a; wdata = d; sel = 1'b1;
    lat = 0;
    do begin
      @(negedge clk); #1;
      lat++;
    end while (!ack && lat < 40);
    got = rdata;
    repeat (holdCyc) @(negedge clk);
    sel = 1'b0;
    #1;
    chk("R2 ack idle", {31'h0, ack}, 32'h0);
    chk("R2 rdata idle", rdata, 32'h0);
    repeat (4) @(negedge clk);
    rd = 1'b0; wdata = $urandom; wordAddr = 11'($urandom);
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    logic [31:0] g; int l;
    access(1'b0, a, d, 2, g, l);
  endtask

  task automatic rdChk(input string req, input logic [10:0] a, input logic [31:0] exp);
    logic [31:0] g; int l;
    access(1'b1, a, 32'h0, 3, g, l);
    chk(req, g, exp);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] got;
    int lat;
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", {31'h0, ack}, 32'h0);
    chk("R1 rdata in reset", rdata, 32'h0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    chk("R1 ctrlOut after reset", ctrlOut, 32'h0);
    running = 1'b1;

    // R3: latency and hold, R6: control write
    access(1'b0, 11'd0, 32'hA5A5_0001, 5, got, lat);
    chk("R3 ack latency", lat, 32'd3);
    chk("R6 ctrlOut after write", ctrlOut, 32'hA5A5_0001);
    access(1'b1, 11'd0, 32'h0, 8, got, lat);
    chk("R4 read control", got, 32'hA5A5_0001);
    chk("R3 read latency", lat, 32'd3);

    // R5: long write of ones to status, event arrives after the commit
    fork
      access(1'b0, 11'd2, 32'hFFFF_FFFF, 20, got, lat);
      begin
        repeat (7) @(negedge clk);
        eventIn = 8'h01;
        @(negedge clk);
        eventIn = 8'h00;
      end
    join
    rdChk("R5 event survives long write", 11'd2, 32'h0000_0001);
    wr(11'd2, 32'h0000_0001);

    // R6: enable width
    wr(11'd1, 32'hFFFF_FFFF);
    rdChk("R6 enable upper bits zero", 11'd1, 32'h0000_00FF);

    // R8, R9: event, W1C
    @(negedge clk); eventIn = 8'h08;
    @(negedge clk); eventIn = 8'h00;
    @(negedge clk); #1;
    chk("R9 irq on enabled event", {31'h0, irq}, 32'h1);
    rdChk("R8 status set", 11'd2, 32'h0000_0008);
    wr(11'd2, 32'h0000_00F7);
    rdChk("R8 write zero keeps bit", 11'd2, 32'h0000_0008);
    wr(11'd1, 32'h0000_0004);
    #1 chk("R9 irq masked", {31'h0, irq}, 32'h0);
    wr(11'd1, 32'h0000_0008);
    #1 chk("R9 irq unmasked", {31'h0, irq}, 32'h1);
    wr(11'd2, 32'h0000_0008);
    rdChk("R8 write one clears", 11'd2, 32'h0);
    #1 chk("R9 irq after clear", {31'h0, irq}, 32'h0);

    // R8: event held through a clearing write
    @(negedge clk); eventIn = 8'h40;
    wr(11'd2, 32'h0000_0040);
    eventIn = 8'h00;
    rdChk("R8 set wins over clear", 11'd2, 32'h0000_0040);
    wr(11'd2, 32'h0000_0040);

    // R6: hardware status read-only
    wr(11'd3, 32'hDEAD_BEEF);
    rdChk("R6 hw status read", 11'd3, 32'h1357_9BDF);
    hwStatus = 32'h2468_ACE0;
    rdChk("R6 hw status live", 11'd3, 32'h2468_ACE0);
    chk("R6 ctrl untouched by word 3", ctrlOut, 32'hA5A5_0001);

    // R7: unmapped addresses
    rdChk("R7 unmapped read zero", 11'h7FF, 32'h0);
    access(1'b1, 11'h100, 32'h0, 1, got, lat);
    chk("R7 unmapped acknowledged", lat, 32'd3);
    wr(11'h104, 32'h0BAD_0BAD);
    chk("R7 unmapped write ignored", ctrlOut, 32'hA5A5_0001);
    rdChk("R7 enable unchanged", 11'd1, 32'h0000_0008);

    // R2: idle bus with traffic on the other inputs
    repeat (5) begin
      @(negedge clk);
      wdata = $urandom; wordAddr = 11'($urandom); rd = 1'($urandom);
      #1;
      chk("R2 idle ack", {31'h0, ack}, 32'h0);
      chk("R2 idle rdata", rdata, 32'h0);
    end
    rd = 1'b0;
    repeat (3) @(negedge clk);

    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule